// File: doc/BRIEF.md
# Platform Power-State Sequencer

This block turns the host's sleep-control pins into one of five system power states (off, soft-off, suspend-to-RAM, active idle, fully active) and drives one enable line per regulator rail so that the set of live rails always moves toward the set that belongs to the current state. Rails change one at a time. A programmable delay separates steps. Rails that are switched off leave in the reverse of the order in which they come up. Two status outputs tell the platform when its resume domain is out of reset and when platform power is good.

Configuration arrives as plain inputs: a per-rail disable mask and the step delay in clock cycles. A strap also chooses between two wake-up policies. In the always-on policy the controller wakes as soon as both internal supply power-goods are present. In the general-purpose policy it also waits for the host enable pin. A low level on the over-temperature pin drops every output at once, in the same cycle, without waiting for a clock edge.

All ports are plain control and status signals. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: The state is decoded from the pins as follows. With host_en=0 or overtemp_n=0 the state is off. With slp_deep_n=0 it is soft-off, whatever slp_susp_n and slp_idle_n are. With slp_deep_n=1 and slp_susp_n=0 it is suspend, and slp_idle_n is ignored. With slp_deep_n=1 and slp_susp_n=1 it is active when slp_idle_n=1 and active-idle when slp_idle_n=0. resume_ready is high in every state except off. plat_pwr_ok is high only in active and active-idle. Both outputs follow the pins with one register of latency.
- R2: The rail bits are rail_en[0] core-logic buck, [1] 1.8 V always buck, [2] 1.24 V always buck, [3] load switch, [4] memory VDDQ buck, [5] VTT LDO, [6] graphics buck, [7] RAM-core buck. The target sets are: off 8'h00, soft-off 8'h07, suspend 8'h1F, active 8'hFF.
- R3: The active-idle target is 8'h1E. It is the active set without bits 0, 5, 6 and 7, and it is not a superset of the suspend set.
- R4: No step ever turns on a rail whose cfg_rail_off bit is 1. Masked rails stay off while the other rails in the target come up.
- R5: Rails turn on one per step in ascending bit order. The first step comes on the first clock edge after the target changes, provided no delay is pending. Later steps follow every step_dly+1 cycles.
- R6: Rails turn off one per step in descending bit order, with the same spacing. All turn-offs that a transition needs happen before any turn-on.
- R7: While overtemp_n is 0, rail_en, resume_ready and plat_pwr_ok are all 0 in the same cycle. The sequence state is cleared, so when the pin returns high the rails come up again from empty.
- R8: With cfg_always_on=1, ctrl_awake goes high one cycle after both pg_core5 and pg_core33 are high, and low one cycle after either one drops. host_en has no effect on it.
- R9: With cfg_always_on=0, ctrl_awake also requires host_en=1. While ctrl_awake is 0, every rail enable and status output is 0.
- R10: While rst_n is low, rail_en, resume_ready, plat_pwr_ok and ctrl_awake are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_always_on | input | 1 | Wake policy: 1 wakes on power-goods alone, 0 also needs host_en |
| pg_core5 | input | 1 | Power-good of the internal 5 V supply |
| pg_core33 | input | 1 | Power-good of the internal 3.3 V supply |
| host_en | input | 1 | Host enable pin |
| slp_deep_n | input | 1 | Deep-sleep control, active low |
| slp_susp_n | input | 1 | Suspend control, active low |
| slp_idle_n | input | 1 | Idle-sleep control, active low |
| overtemp_n | input | 1 | Over-temperature trip, active low |
| cfg_rail_off | input | 8 | Per-rail disable mask, 1 keeps that rail off |
| step_dly | input | 8 | Extra idle cycles between rail steps |
| rail_en | output | 8 | Rail enables, bit order as in R2 |
| resume_ready | output | 1 | Resume domain released from reset |
| plat_pwr_ok | output | 1 | Platform power good |
| ctrl_awake | output | 1 | Controller out of reset |

## Verification
The embedded properties assume that cfg_rail_off and step_dly are only changed while the sequence is idle, and that the pins hold steady for at least one cycle after each change. The step-spacing and rise-inside-target checks compare against the target and delay from the previous cycle. The bench writes every input on the falling clock edge and changes the mask or the delay only once the rails have settled. It waits out the longest possible sequence before it moves the pins again. The over-temperature pin is the one input that is checked combinationally: the bench samples a moment after the pin falls, still inside the same cycle.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int NRAIL = 8;

  typedef enum logic [2:0] {
    PS_OFF   = 3'd0,
    PS_SOFT  = 3'd1,
    PS_SUSP  = 3'd2,
    PS_IDLE  = 3'd3,
    PS_ACT   = 3'd4
  } pstate_e;

  localparam int RL_CORE  = 0;
  localparam int RL_A18   = 1;
  localparam int RL_A124  = 2;
  localparam int RL_LSW   = 3;
  localparam int RL_VDDQ  = 4;
  localparam int RL_VTT   = 5;
  localparam int RL_GFX   = 6;
  localparam int RL_RAM   = 7;

  function automatic logic [NRAIL-1:0] rail_set(pstate_e s);
    logic [NRAIL-1:0] m;
    m = '0;
    if (s != PS_OFF) begin
      m[RL_CORE] = 1'b1;
      m[RL_A18]  = 1'b1;
      m[RL_A124] = 1'b1;
    end
    if (s == PS_SUSP || s == PS_IDLE || s == PS_ACT) begin
      m[RL_LSW]  = 1'b1;
      m[RL_VDDQ] = 1'b1;
    end
    if (s == PS_ACT) begin
      m[RL_VTT] = 1'b1;
      m[RL_GFX] = 1'b1;
      m[RL_RAM] = 1'b1;
    end
    if (s == PS_IDLE) m[RL_CORE] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/pwr_state_decode.sv
module pwr_state_decode
  import pwr_seq_pkg::*;
(
  input  logic    host_en,
  input  logic    slp_deep_n,
  input  logic    slp_susp_n,
  input  logic    slp_idle_n,
  input  logic    overtemp_n,
  output pstate_e state
);
  always_comb begin
    if (!host_en || !overtemp_n)  state = PS_OFF;
    else if (!slp_deep_n)         state = PS_SOFT;
    else if (!slp_susp_n)         state = PS_SUSP;
    else if (!slp_idle_n)         state = PS_IDLE;
    else                          state = PS_ACT;
  end
endmodule

// File: rtl/pwr_wake_gate.sv
module pwr_wake_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_always_on,
  input  logic pg_a,
  input  logic pg_b,
  input  logic host_en,
  output logic awake_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) awake_q <= 1'b0;
    else        awake_q <= pg_a & pg_b & (cfg_always_on | host_en);
  end

  AST_AWAKE_NEEDS_PG: assert property (@(posedge clk) disable iff (!rst_n)
    awake_q |-> $past(pg_a && pg_b)); // R8

  AST_GP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (awake_q && !$past(cfg_always_on)) |-> $past(host_en)); // R9
endmodule

// File: rtl/pwr_rail_stepper.sv
module pwr_rail_stepper #(
  parameter int NRAIL = 8,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [NRAIL-1:0] tgt,
  input  logic [DLY_W-1:0] step_dly,
  output logic [NRAIL-1:0] rails_q
);
  localparam int IDX_W = (NRAIL > 1) ? $clog2(NRAIL) : 1;

  logic [DLY_W-1:0] dly_q;
  logic [NRAIL-1:0] need_off, need_on;
  logic [IDX_W-1:0] off_idx, on_idx;
  logic             off_hit, on_hit;

  always_comb begin
    need_off = rails_q & ~tgt;
    need_on  = tgt & ~rails_q;
    off_idx  = '0;
    off_hit  = 1'b0;
    for (int i = 0; i < NRAIL; i++) begin
      if (need_off[i]) begin
        off_idx = IDX_W'(i);
        off_hit = 1'b1;
      end
    end
    on_idx = '0;
    on_hit = 1'b0;
    for (int i = NRAIL - 1; i >= 0; i--) begin
      if (need_on[i]) begin
        on_idx = IDX_W'(i);
        on_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rails_q <= '0;
      dly_q   <= '0;
    end else if (!run) begin
      rails_q <= '0;
      dly_q   <= '0;
    end else if (dly_q != '0) begin
      dly_q <= dly_q - 1'b1;
    end else if (off_hit) begin
      rails_q[off_idx] <= 1'b0;
      dly_q            <= step_dly;
    end else if (on_hit) begin
      rails_q[on_idx] <= 1'b1;
      dly_q           <= step_dly;
    end
  end

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> ($countones(rails_q ^ $past(rails_q)) <= 1)); // R5

  AST_RISE_IN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ((rails_q & ~$past(rails_q) & ~$past(tgt)) == '0)); // R4

  AST_FALL_OFF_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> ((~rails_q & $past(rails_q) & $past(tgt)) == '0)); // R6

  AST_CLEAR_ON_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> (rails_q == '0)); // R7

  AST_STEP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && rails_q != $past(rails_q)) |-> ($past(dly_q) == '0)); // R5
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_always_on,
  input  logic             pg_core5,
  input  logic             pg_core33,
  input  logic             host_en,
  input  logic             slp_deep_n,
  input  logic             slp_susp_n,
  input  logic             slp_idle_n,
  input  logic             overtemp_n,
  input  logic [NRAIL-1:0] cfg_rail_off,
  input  logic [DLY_W-1:0] step_dly,
  output logic [NRAIL-1:0] rail_en,
  output logic             resume_ready,
  output logic             plat_pwr_ok,
  output logic             ctrl_awake
);
  pstate_e          state;
  logic             awake_q, run;
  logic [NRAIL-1:0] tgt, rails_q;
  logic             rsm_q, pok_q;

  pwr_state_decode u_dec (
    .host_en    (host_en),
    .slp_deep_n (slp_deep_n),
    .slp_susp_n (slp_susp_n),
    .slp_idle_n (slp_idle_n),
    .overtemp_n (overtemp_n),
    .state      (state)
  );

  pwr_wake_gate u_wake (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_always_on (cfg_always_on),
    .pg_a          (pg_core5),
    .pg_b          (pg_core33),
    .host_en       (host_en),
    .awake_q       (awake_q)
  );

  assign run = awake_q & overtemp_n;
  assign tgt = rail_set(state) & ~cfg_rail_off;

  pwr_rail_stepper #(.NRAIL(NRAIL), .DLY_W(DLY_W)) u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tgt      (tgt),
    .step_dly (step_dly),
    .rails_q  (rails_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsm_q <= 1'b0;
      pok_q <= 1'b0;
    end else begin
      rsm_q <= run && (state != PS_OFF);
      pok_q <= run && (state == PS_ACT || state == PS_IDLE);
    end
  end

  assign rail_en      = rails_q & {NRAIL{run}};
  assign resume_ready = rsm_q & run;
  assign plat_pwr_ok  = pok_q & run;
  assign ctrl_awake   = awake_q;

  AST_OK_NEEDS_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    pok_q |-> rsm_q); // R1

  AST_STATUS_TRACKS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    rsm_q |-> $past(host_en && overtemp_n)); // R1
endmodule

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_always_on = 1'b1;
  logic       pg_core5 = 1'b1, pg_core33 = 1'b1;
  logic       host_en = 1'b0, slp_deep_n = 1'b0, slp_susp_n = 1'b0, slp_idle_n = 1'b0;
  logic       overtemp_n = 1'b0;
  logic [7:0] cfg_rail_off = 8'h00;
  logic [7:0] step_dly = 8'd3;
  logic [7:0] rail_en;
  logic       resume_ready, plat_pwr_ok, ctrl_awake;

  int n_vec = 0, n_bad = 0;
  int ev_idx[32];
  bit ev_on[32];
  int ev_cyc[32];
  int n_ev;

  always #4 clk = ~clk;

  pwr_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_always_on(cfg_always_on),
    .pg_core5(pg_core5), .pg_core33(pg_core33), .host_en(host_en),
    .slp_deep_n(slp_deep_n), .slp_susp_n(slp_susp_n), .slp_idle_n(slp_idle_n),
    .overtemp_n(overtemp_n), .cfg_rail_off(cfg_rail_off), .step_dly(step_dly),
    .rail_en(rail_en), .resume_ready(resume_ready), .plat_pwr_ok(plat_pwr_ok),
    .ctrl_awake(ctrl_awake)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pins(bit en, bit d, bit s, bit i, bit t);
    @(negedge clk);
    host_en = en; slp_deep_n = d; slp_susp_n = s; slp_idle_n = i; overtemp_n = t;
  endtask

  task automatic log_cycles(int n);
    logic [7:0] prev;
    prev = rail_en;
    n_ev = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      for (int b = 0; b < 8; b++)
        if (rail_en[b] !== prev[b] && n_ev < 32) begin
          ev_idx[n_ev] = b; ev_on[n_ev] = rail_en[b]; ev_cyc[n_ev] = c; n_ev++;
        end
      prev = rail_en;
    end
  endtask

  task automatic expect_ev(string req, int n, int idx[8], bit on[8], int gap);
    chk({req, " event count"}, n_ev, n);
    for (int k = 0; k < n && k < n_ev; k++) begin
      chk({req, " rail index"}, ev_idx[k], idx[k]);
      chk({req, " direction"}, ev_on[k], on[k]);
      chk({req, " step cycle"}, ev_cyc[k], k * gap);
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R10 rail_en in reset", rail_en, 0);
    chk("R10 resume_ready in reset", resume_ready, 0);
    chk("R10 plat_pwr_ok in reset", plat_pwr_ok, 0);
    chk("R10 ctrl_awake in reset", ctrl_awake, 0);
  endtask

  task automatic t_wake();
    cfg_always_on = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 asleep without host_en", ctrl_awake, 0);
    pins(1, 0, 0, 1, 1);
    @(negedge clk);
    chk("R9 awake with host_en", ctrl_awake, 1);
    pins(0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R9 asleep after host_en low", ctrl_awake, 0);
    cfg_always_on = 1'b1;
    @(negedge clk);
    chk("R8 awake on power-goods alone", ctrl_awake, 1);
    pg_core33 = 1'b0;
    @(negedge clk);
    chk("R8 asleep when one power-good drops", ctrl_awake, 0);
    pg_core33 = 1'b1;
    @(negedge clk);
    chk("R8 awake again", ctrl_awake, 1);
  endtask

  task automatic t_power_up();
    pins(1, 0, 0, 1, 1);
    log_cycles(20);
    expect_ev("R5 soft-off on order", 3, '{0, 1, 2, 0, 0, 0, 0, 0}, '{1, 1, 1, 0, 0, 0, 0, 0}, 4);
    chk("R2 soft-off set", rail_en, 8'h07);
    chk("R1 soft-off resume_ready", resume_ready, 1);
    chk("R1 soft-off plat_pwr_ok", plat_pwr_ok, 0);
    pins(1, 1, 0, 1, 1);
    log_cycles(16);
    expect_ev("R5 suspend on order", 2, '{3, 4, 0, 0, 0, 0, 0, 0}, '{1, 1, 0, 0, 0, 0, 0, 0}, 4);
    chk("R2 suspend set", rail_en, 8'h1F);
    chk("R1 suspend plat_pwr_ok", plat_pwr_ok, 0);
    pins(1, 1, 0, 0, 1);
    repeat (3) @(negedge clk);
    chk("R1 idle pin ignored in suspend, rails", rail_en, 8'h1F);
    chk("R1 idle pin ignored in suspend, pwr_ok", plat_pwr_ok, 0);
    pins(1, 1, 1, 1, 1);
    log_cycles(20);
    expect_ev("R5 active on order", 3, '{5, 6, 7, 0, 0, 0, 0, 0}, '{1, 1, 1, 0, 0, 0, 0, 0}, 4);
    chk("R2 active set", rail_en, 8'hFF);
    chk("R1 active resume_ready", resume_ready, 1);
    chk("R1 active plat_pwr_ok", plat_pwr_ok, 1);
  endtask

  task automatic t_idle();
    pins(1, 1, 1, 0, 1);
    log_cycles(24);
    expect_ev("R6 active-idle off order", 4, '{7, 6, 5, 0, 0, 0, 0, 0}, '{0, 0, 0, 0, 0, 0, 0, 0}, 4);
    chk("R3 active-idle set", rail_en, 8'h1E);
    chk("R1 active-idle plat_pwr_ok", plat_pwr_ok, 1);
    pins(1, 0, 1, 0, 1);
    log_cycles(20);
    expect_ev("R6 off before on", 3, '{4, 3, 0, 0, 0, 0, 0, 0}, '{0, 0, 1, 0, 0, 0, 0, 0}, 4);
    chk("R2 soft-off from idle", rail_en, 8'h07);
    chk("R1 deep pin dominates", plat_pwr_ok, 0);
  endtask

  task automatic t_mask();
    pins(0, 0, 0, 0, 1);
    log_cycles(20);
    chk("R6 off state reached", rail_en, 8'h00);
    chk("R1 off state resume_ready", resume_ready, 0);
    step_dly = 8'd0;
    cfg_rail_off = 8'h41;
    pins(1, 1, 1, 1, 1);
    log_cycles(12);
    expect_ev("R4 masked bring-up", 6, '{1, 2, 3, 4, 5, 7, 0, 0}, '{1, 1, 1, 1, 1, 1, 0, 0}, 1);
    chk("R4 masked rails stay off", rail_en, 8'hBE);
    cfg_rail_off = 8'h00;
    step_dly = 8'd3;
    log_cycles(12);
    chk("R2 full set after unmask", rail_en, 8'hFF);
  endtask

  task automatic t_trip();
    @(negedge clk);
    #1 overtemp_n = 1'b0;
    #1;
    chk("R7 rails dark same cycle", rail_en, 0);
    chk("R7 resume_ready dark same cycle", resume_ready, 0);
    chk("R7 pwr_ok dark same cycle", plat_pwr_ok, 0);
    @(negedge clk);
    chk("R7 rails stay dark", rail_en, 0);
    overtemp_n = 1'b1;
    log_cycles(40);
    expect_ev("R7 restart from empty", 8, '{0, 1, 2, 3, 4, 5, 6, 7}, '{1, 1, 1, 1, 1, 1, 1, 1}, 4);
    chk("R7 recovered rails", rail_en, 8'hFF);
  endtask

  task automatic t_gp_gate();
    cfg_always_on = 1'b0;
    pins(0, 1, 1, 1, 1);
    log_cycles(4);
    chk("R9 rails low when asleep", rail_en, 0);
    chk("R9 awake low", ctrl_awake, 0);
    cfg_always_on = 1'b1;
  endtask

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_wake();
    t_power_up();
    t_idle();
    t_mask();
    t_trip();
    t_gp_gate();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule